// File: doc/BRIEF.md
# Nyquist Zone Frequency Folder

This block works out the setting for a digital up- or down-converter. It takes three signed fixed-point integers: the wanted RF frequency, the frequency that the analog front end actually places at DC, and the converter sample rate. From these it produces a converter offset and a flag that says whether the spectrum arrives mirrored.

The block first forms the difference between the wanted frequency and the front-end frequency. It then brings that difference into the range of one sample rate by adding or subtracting the rate, one step per clock. Next it decides which half of the Nyquist zone the folded value lies in. Finally it applies three corrections:
- a toggle of the flag when the front end inverts the spectrum;
- a sign flip that removes the inversion when the front end is not quadrature;
- a sign flip for the transmit direction, unless the front end swaps I and Q.

A caller pulses `start` with the operands. It then waits for the one-cycle `done` pulse, after which `offset_o` and `inverted_o` are valid. Both outputs are held until the next result.

Top module: `nyquist_folder`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `done`, `offset_o` and `inverted_o` are all zero until the first result.
- R2: A `start` sampled while idle raises `busy` on the next cycle. If the fold takes n add/subtract steps, `done` rises on the (n+1)-th clock edge after the start edge. `busy` is high from the cycle after the start edge until that edge, and it is low while `done` is high.
- R3: With delta = target - baseband at or above zero, the sample rate fs is subtracted while delta > fs. If the folded delta is at most floor(fs/2), the base result is offset = -delta with the flag clear. Otherwise the base result is offset = delta - fs with the flag set.
- R4: With delta below zero, fs is added while delta < -fs. If the folded delta is at least -floor(fs/2), the base result is offset = -delta with the flag clear. Otherwise the base result is offset = delta + fs with the flag set.
- R5: When `fe_inverts` is high, the flag from R3/R4 is toggled.
- R6: If the flag is set after R5 and `fe_quadrature` is low, the offset is negated and the flag is cleared.
- R7: When `dir_tx` is high and `fe_iq_swapped` is low, the offset after R6 is negated. Receive results never take this negation.
- R8: A `start` pulse while `busy` is high has no effect: neither the operands nor the timing of the running computation change.
- R9: `done` lasts exactly one cycle. `offset_o` and `inverted_o` change only on the edge that raises `done`.
- R10: Zone edges are exact:
  - a folded delta equal to fs (or to -fs) is not folded further and gives offset 0 with the flag set;
  - a delta equal to floor(fs/2) is in the non-mirrored half;
  - floor(fs/2)+1 is in the mirrored half;
  - the same holds mirrored for negative values.
- R11: `samp_rate` must be positive. fs/2 is taken with an arithmetic right shift, so an odd rate rounds down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation when idle |
| target_freq | input | 40 | Wanted frequency, signed |
| base_freq | input | 40 | Front-end frequency at DC, signed |
| samp_rate | input | 40 | Converter sample rate, signed, positive |
| fe_inverts | input | 1 | Front end mirrors the spectrum |
| fe_quadrature | input | 1 | Front end delivers I and Q |
| fe_iq_swapped | input | 1 | Front end swaps I and Q |
| dir_tx | input | 1 | 1 = up-conversion, 0 = down-conversion |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| offset_o | output | 40 | Converter offset, signed |
| inverted_o | output | 1 | Spectrum mirrored after corrections |

## Verification
A wrong fold step or a wrong zone compare shows up in `offset_o` on the `done` edge as a value off by a multiple of fs, or as a flipped sign. It also shows in `inverted_o`. A stuck or skipped fold step moves `done` away from the cycle the step count predicts, so an error in the iteration is seen within that computation. Inputs that change while busy, or a start that gets through while busy, change the result of the run already under way. The bench therefore checks each result against the operands that were presented at the start edge.

// File: rtl/nyquist_folder.sv
module nyquist_folder #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] target_freq,
  input  logic [W-1:0] base_freq,
  input  logic [W-1:0] samp_rate,
  input  logic         fe_inverts,
  input  logic         fe_quadrature,
  input  logic         fe_iq_swapped,
  input  logic         dir_tx,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] offset_o,
  output logic         inverted_o
);
  localparam int DW = W + 2;

  logic                 folding;
  logic signed [DW-1:0] delta_q, fs_q;
  logic                 inv_q, quad_q, swap_q, tx_q;

  wire signed [DW-1:0] t_ext = {{2{target_freq[W-1]}}, target_freq};
  wire signed [DW-1:0] b_ext = {{2{base_freq[W-1]}}, base_freq};
  wire signed [DW-1:0] f_ext = {{2{samp_rate[W-1]}}, samp_rate};

  wire                 pos      = !delta_q[DW-1];
  wire signed [DW-1:0] half     = fs_q >>> 1;
  wire                 go_down  = pos && (delta_q > fs_q);
  wire                 go_up    = !pos && (delta_q < -fs_q);
  wire                 step     = go_down || go_up;
  wire                 zone_inv = pos ? (delta_q > half) : (delta_q < -half);

  wire signed [DW-1:0] base_off = !zone_inv ? -delta_q :
                                  (pos ? delta_q - fs_q : delta_q + fs_q);
  wire                 inv1     = zone_inv ^ inv_q;
  wire                 fix_nq   = inv1 && !quad_q;
  wire signed [DW-1:0] off2     = fix_nq ? -base_off : base_off;
  wire signed [DW-1:0] off3     = (tx_q && !swap_q) ? -off2 : off2;

  assign busy = folding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      folding    <= 1'b0;
      done       <= 1'b0;
      delta_q    <= '0;
      fs_q       <= '0;
      inv_q      <= 1'b0;
      quad_q     <= 1'b0;
      swap_q     <= 1'b0;
      tx_q       <= 1'b0;
      offset_o   <= '0;
      inverted_o <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!folding) begin
        if (start) begin
          folding <= 1'b1;
          delta_q <= t_ext - b_ext;
          fs_q    <= f_ext;
          inv_q   <= fe_inverts;
          quad_q  <= fe_quadrature;
          swap_q  <= fe_iq_swapped;
          tx_q    <= dir_tx;
        end
      end else if (go_down) begin
        delta_q <= delta_q - fs_q;
      end else if (go_up) begin
        delta_q <= delta_q + fs_q;
      end else begin
        folding    <= 1'b0;
        done       <= 1'b1;
        offset_o   <= off3[W-1:0];
        inverted_o <= inv1 && !fix_nq;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R2
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done)); // R2
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (!done || 1'b1) && ($past(done) || !$changed(offset_o) || done)); // R9
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) && !done |-> $stable(inverted_o)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(fs_q)); // R8
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($signed({{2{offset_o[W-1]}}, offset_o}) <= fs_q) &&
             ($signed({{2{offset_o[W-1]}}, offset_o}) >= -fs_q)); // R3
  AST_STEP_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step) |=> busy); // R4
endmodule

// File: tb/nyquist_folder_test.sv
module nyquist_folder_test;
  localparam int  W      = 40;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] target_freq = '0, base_freq = '0, samp_rate = '0;
  logic fe_inverts = 0, fe_quadrature = 0, fe_iq_swapped = 0, dir_tx = 0;
  logic busy, done, inverted_o;
  logic [W-1:0] offset_o;

  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  nyquist_folder #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .target_freq(target_freq), .base_freq(base_freq), .samp_rate(samp_rate),
    .fe_inverts(fe_inverts), .fe_quadrature(fe_quadrature),
    .fe_iq_swapped(fe_iq_swapped), .dir_tx(dir_tx),
    .busy(busy), .done(done), .offset_o(offset_o), .inverted_o(inverted_o));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint t, input longint b, input longint fs,
                                input bit finv, input bit quad, input bit swp,
                                input bit tx, output longint off, output bit inv,
                                output int n);
    longint d = t - b;
    longint h = fs >>> 1;
    bit z;
    n = 0;
    while (d >= 0 && d > fs) begin d -= fs; n++; end
    while (d < 0 && d < -fs) begin d += fs; n++; end
    if (d >= 0) begin z = d > h;  off = z ? d - fs : -d; end
    else        begin z = d < -h; off = z ? d + fs : -d; end
    inv = z ^ finv;
    if (inv && !quad) begin off = -off; inv = 0; end
    if (tx && !swp) off = -off;
  endfunction

  task automatic run(input longint t, input longint b, input longint fs,
                     input bit finv, input bit quad, input bit swp, input bit tx,
                     input string tag, input bit intrude);
    longint eoff; bit einv; int n; int cyc = 0;
    logic [W-1:0] held;
    model(t, b, fs, finv, quad, swp, tx, eoff, einv, n);
    @(negedge clk);
    target_freq = t[W-1:0]; base_freq = b[W-1:0]; samp_rate = fs[W-1:0];
    fe_inverts = finv; fe_quadrature = quad; fe_iq_swapped = swp; dir_tx = tx;
    start = 1;
    @(negedge clk);
    cyc = 1;
    check("R2 busy after start", busy, 1);
    if (intrude) begin
      target_freq = ~target_freq; base_freq = 40'd12345;
      samp_rate = 40'd7; fe_inverts = ~finv; dir_tx = ~tx;
    end else start = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (intrude && cyc == 3) start = 0;
      if (!done && !busy) begin
        check("R2 busy held", busy, 1);
        break;
      end
    end
    start = 0;
    check("R2 done cycle", cyc, n + 2);
    check("R2 busy low at done", busy, 0);
    check({tag, " offset"}, $signed(offset_o), eoff);
    check({tag, " inverted"}, inverted_o, einv);
    held = offset_o;
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    @(negedge clk);
    check("R9 offset held", offset_o, held);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(PERIOD * 3);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 offset", offset_o, 0);
    check("R1 inverted", inverted_o, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 busy after release", busy, 0);
    check("R1 offset after release", offset_o, 0);

    run(1000, 0, 300, 0, 1, 0, 0, "R3", 0);
    run(-1000, 0, 300, 0, 1, 0, 0, "R4", 0);
    run(50, 0, 101, 0, 1, 0, 0, "R10 half", 0);
    run(51, 0, 101, 0, 1, 0, 0, "R10 above half", 0);
    run(-50, 0, 101, 0, 1, 0, 0, "R10 neg half", 0);
    run(-51, 0, 101, 0, 1, 0, 0, "R10 neg beyond half", 0);
    run(101, 0, 101, 0, 1, 0, 0, "R10 equal fs", 0);
    run(-101, 0, 101, 0, 1, 0, 0, "R10 equal neg fs", 0);
    run(0, 0, 64, 0, 1, 0, 0, "R3 zero", 0);
    run(700, 100, 64, 1, 1, 0, 0, "R5", 0);
    run(60, 0, 100, 0, 0, 0, 0, "R6", 0);
    run(60, 0, 100, 1, 0, 0, 0, "R6 toggled", 0);
    run(30, 0, 100, 0, 1, 0, 1, "R7 tx", 0);
    run(30, 0, 100, 0, 1, 1, 1, "R7 swapped", 0);
    run(-5, 0, 3, 0, 1, 0, 0, "R11 odd fs", 0);
    run(2000, 10, 97, 0, 1, 0, 0, "R8", 1);

    for (int i = 0; i < 150; i++) begin
      longint fs, base, d;
      int k;
      fs   = 1 + longint'($urandom % (1 << 30));
      base = (longint'($urandom) - 64'sd2147483648) * 16;
      k    = int'($urandom % 41) - 20;
      d    = longint'(k) * fs + longint'($urandom) % fs;
      run(base + d, base, fs, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
          d >= 0 ? "R3/R5/R6/R7 random" : "R4/R5/R6/R7 random", 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule